// File: doc/BRIEF.md
# Kick-Line Watchdog with Repeating Reset Pulses

This block supervises a processor by watching a single kick line. Every level change on that line, rising or falling, proves the software is alive and restarts a timeout window. The window is counted in ticks of a 32.768 kHz enable, so the block runs on any fast system clock while its timing stays tied to the slow time base. If a whole window passes with no kick edge, the block drives an active-low fail flag and starts an active-low reset pulse. The pulse lasts one sixth of the selected window.

The fail flag stays low until the kick line moves again. If the line stays stuck, a new reset pulse is issued once every window. A 3-bit select chooses one of eight windows. A disable input, which stands in for a floating kick line, and a power-good input, which is low when main power is out of tolerance or the system runs from backup, both put the watchdog to sleep with both outputs released.

The kick line passes through a two-flop synchroniser and an edge detector. All counting is scaled by the parameter `UNIT`, which is the reset width of select 001 in ticks. Its default of 128 gives the real-time values.

Top module: `kick_watchdog`

## Requirements
- R1: A kick edge (either polarity) restarts the window three clock cycles after it appears at `kick_i`. On that same cycle `fail_no` and `rst_no` return high, which cuts any running reset pulse short.
- R2: With the block enabled and no restart, `fail_no` falls exactly T ticks after the last restart. T in multiples of `UNIT` is 384 for select 000, 6 for 001, 12 for 010, 24 for 011, 48 for 100, 96 for 101, 192 for 110 and 768 for 111. With the default `UNIT` this gives 49152, 768, 1536, 3072, 6144, 12288, 24576 and 98304 ticks.
- R3: `rst_no` falls on the same cycle as `fail_no` and stays low for exactly T/6 ticks.
- R4: Once low, `fail_no` stays low until a kick edge, a select change or a disable.
- R5: While the kick line stays stuck, a further reset pulse of the same width starts every T ticks, and `fail_no` stays low throughout.
- R6: While `hold_off_i` is 1, both outputs are high one cycle later, the window is held at zero and kick edges have no effect. After release, the first timeout comes T ticks later.
- R7: While `pwr_ok_i` is 0, the block behaves as in R6. This includes ending an active fail and reset pulse on the next cycle.
- R8: A change of `tsel_i` restarts the window on the next clock edge, and the new T applies.
- R9: Clock cycles with `tick_i` low neither advance the window nor shorten a reset pulse.
- R10: During and right after `rst_ni` both outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz tick enable, one clock wide |
| kick_i | input | 1 | Asynchronous kick line from software |
| hold_off_i | input | 1 | 1 = watchdog disabled (kick line floating) |
| pwr_ok_i | input | 1 | 1 = main power good and not in backup |
| tsel_i | input | 3 | Timeout select |
| fail_no | output | 1 | Watchdog fail, active low, latched |
| rst_no | output | 1 | Reset pulse, active low |

## Verification
The main function is driven with a kick line that stays stuck for several windows, which separates the first timeout from the repeated pulses and measures both the period and the width. It is also driven with a kick edge that lands while the fail flag is low, and with one that lands in the middle of a reset pulse, which tells release apart from the natural end of a pulse. Select changes in mid-window, gaps in the tick enable, and disable or power loss during an active fail each shift or cancel a timeout by a known number of cycles. The scoreboard flags any output edge that arrives early, late or unannounced. Selects 000, 001, 010 and 111 are timed end to end.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  // reset width in UNIT ticks; the window is six times this
  function automatic int unsigned kwd_width_mult(input logic [2:0] sel);
    case (sel)
      3'd0:    return 64;
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 4;
      3'd4:    return 8;
      3'd5:    return 16;
      3'd6:    return 32;
      default: return 128;
    endcase
  endfunction
endpackage

// File: rtl/kwd_kick_sync.sv
module kwd_kick_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic edge_o
);
  logic [2:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[1:0], kick_i};
  end

  assign edge_o = s_q[1] ^ s_q[2];
endmodule

// File: rtl/kwd_window.sv
module kwd_window #(
  parameter int CW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end   = (cnt_q == limit_i - CW'(1));
  assign expire_o = en_i && tick_i && !restart_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || restart_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= at_end ? '0 : cnt_q + CW'(1);
  end

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> cnt_q < limit_i); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0); // R8
  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i && !restart_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
  parameter int WW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic          expire_i,
  input  logic [WW-1:0] width_i,
  output logic          fail_no,
  output logic          rst_no
);
  logic          fail_q;
  logic [WW-1:0] rcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      rcnt_q <= '0;
    end else if (!en_i || restart_i) begin
      fail_q <= 1'b0;
      rcnt_q <= '0;
    end else begin
      if (expire_i) fail_q <= 1'b1;
      if (expire_i)                      rcnt_q <= width_i;
      else if (tick_i && rcnt_q != '0)   rcnt_q <= rcnt_q - WW'(1);
    end
  end

  assign fail_no = !fail_q;
  assign rst_no  = (rcnt_q == '0);

  AST_FAIL_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && en_i && !restart_i) |=> fail_q); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (fail_no && rst_no)); // R6
  AST_PULSE_WITH_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> !fail_no); // R5
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
  import kwd_pkg::*;
#(
  parameter int UNIT = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       hold_off_i,
  input  logic       pwr_ok_i,
  input  logic [2:0] tsel_i,
  output logic       fail_no,
  output logic       rst_no
);
  localparam int MAX_W = 128 * UNIT;
  localparam int MAX_T = 6 * MAX_W;
  localparam int CW    = $clog2(MAX_T + 1);
  localparam int WW    = $clog2(MAX_W + 1);

  logic          kick_edge;
  logic [2:0]    sel_q;
  logic          restart;
  logic          en;
  logic          expire;
  logic [WW-1:0] width;
  logic [CW-1:0] limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 3'd0;
    else         sel_q <= tsel_i;
  end

  assign en      = !hold_off_i && pwr_ok_i;
  assign restart = kick_edge || (tsel_i != sel_q);
  assign width   = WW'(kwd_width_mult(tsel_i) * UNIT);
  assign limit   = CW'(6 * kwd_width_mult(tsel_i) * UNIT);

  kwd_kick_sync i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .edge_o (kick_edge)
  );

  kwd_window #(.CW(CW)) i_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .tick_i    (tick_i),
    .restart_i (restart),
    .limit_i   (limit),
    .expire_o  (expire)
  );

  kwd_pulse #(.WW(WW)) i_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .tick_i    (tick_i),
    .restart_i (restart),
    .expire_i  (expire),
    .width_i   (width),
    .fail_no   (fail_no),
    .rst_no    (rst_no)
  );
endmodule

// File: tb/test_kick_watchdog.sv
module test_kick_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int U  = 4;
  localparam int T1 = 6 * U,   W1 = U;
  localparam int T2 = 12 * U,  W2 = 2 * U;
  localparam int T0 = 384 * U, W0 = 64 * U;
  localparam int T7 = 768 * U, W7 = 128 * U;
  localparam int WDOG = 20000;

  logic clk = 0, rst_n = 0, tick = 1, kick = 0, hold_off = 1, pwr_ok = 1;
  logic [2:0] tsel = 3'd1;
  logic fail_n, rst_out_n;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit sig; bit lvl; int at; string req; } ev_t;
  ev_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  kick_watchdog #(.UNIT(U)) i_kick_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .kick_i(kick),
    .hold_off_i(hold_off), .pwr_ok_i(pwr_ok), .tsel_i(tsel),
    .fail_no(fail_n), .rst_no(rst_out_n)
  );

  // sig: 0 = fail_no, 1 = rst_no
  task automatic push(bit sig, bit lvl, int at, string req);
    ev_t e; e.sig = sig; e.lvl = lvl; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic toggle_kick();
    kick = ~kick;
  endtask

  task automatic observe(bit sig, bit lvl);
    ev_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL unexpected: sig=%0d lvl=%0d at %0d (expected none)", sig, lvl, cyc);
    end else begin
      e = q.pop_front();
      if (e.sig != sig || e.lvl != lvl || e.at != cyc) begin
        errors++;
        $display("FAIL %s: got sig=%0d lvl=%0d at %0d, expected sig=%0d lvl=%0d at %0d",
                 e.req, sig, lvl, cyc, e.sig, e.lvl, e.at);
      end
    end
  endtask

  // monitor
  bit pf = 1, pr = 1;
  always @(negedge clk) begin
    if (fail_n !== pf) begin observe(0, fail_n); pf = fail_n; end
    if (rst_out_n !== pr) begin observe(1, rst_out_n); pr = rst_out_n; end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cyc >= WDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung at %0d (expected end before %0d)", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++; // R10
    if (fail_n !== 1 || rst_out_n !== 1) begin
      errors++;
      $display("FAIL R10: fail_no=%b rst_no=%b expected 1 1", fail_n, rst_out_n);
    end
    repeat (5) @(negedge clk);

    // R6 release, R2/R3/R5 stuck kick with select 001
    c = cyc; hold_off = 0;
    push(0, 0, c + T1, "R2"); push(1, 0, c + T1, "R3"); push(1, 1, c + T1 + W1, "R3");
    push(1, 0, c + 2*T1, "R5"); push(1, 1, c + 2*T1 + W1, "R5");
    wait_to(c + 2*T1 + 12);
    // R1/R4 kick releases latched fail
    c = cyc; toggle_kick();
    push(0, 1, c + 3, "R4");
    push(0, 0, c + 3 + T1, "R1"); push(1, 0, c + 3 + T1, "R1"); push(1, 1, c + 3 + T1 + W1, "R1");
    wait_to(c + 40);
    c = cyc; toggle_kick();
    push(0, 1, c + 3, "R1");
    push(0, 0, c + 3 + T1, "R2"); push(1, 0, c + 3 + T1, "R3");
    wait_to(c + 3 + T1);
    // R1 kick cuts a running pulse short
    c = cyc; toggle_kick();
    push(0, 1, c + 3, "R1"); push(1, 1, c + 3, "R1");
    wait_to(c + 13);
    // R6 disable: no events, kicks ignored
    hold_off = 1;
    wait_to(cyc + 20); toggle_kick();
    wait_to(cyc + 100);
    // R8 select change mid-window
    c = cyc; hold_off = 0;
    wait_to(c + 10);
    c = cyc; tsel = 3'd2;
    push(0, 0, c + 1 + T2, "R8"); push(1, 0, c + 1 + T2, "R8"); push(1, 1, c + 1 + T2 + W2, "R8");
    wait_to(c + 1 + T2 + W2 + 2);
    c = cyc; toggle_kick();
    push(0, 1, c + 3, "R4");
    push(0, 0, c + 3 + T2, "R2"); push(1, 0, c + 3 + T2, "R3");
    wait_to(c + 3 + T2 + 2);
    // R7 power loss during an active pulse
    c = cyc; pwr_ok = 0;
    push(0, 1, c + 1, "R7"); push(1, 1, c + 1, "R7");
    wait_to(c + 30); toggle_kick(); wait_to(c + 60);
    c = cyc; pwr_ok = 1;
    push(0, 0, c + T2 + 10, "R9"); push(1, 0, c + T2 + 10, "R9"); push(1, 1, c + T2 + 10 + W2, "R9");
    // R9 ten cycles without tick
    wait_to(c + 10); tick = 0;
    wait_to(c + 20); tick = 1;
    wait_to(c + T2 + 10 + W2 + 3);
    c = cyc; toggle_kick();
    push(0, 1, c + 3, "R4");
    wait_to(c + 10);
    // R2 select 000
    c = cyc; tsel = 3'd0;
    push(0, 0, c + 1 + T0, "R2"); push(1, 0, c + 1 + T0, "R3"); push(1, 1, c + 1 + T0 + W0, "R3");
    wait_to(c + 1 + T0 + W0 + 5);
    c = cyc; toggle_kick();
    push(0, 1, c + 3, "R4");
    wait_to(c + 10);
    // R2 select 111
    c = cyc; tsel = 3'd7;
    push(0, 0, c + 1 + T7, "R2"); push(1, 0, c + 1 + T7, "R3"); push(1, 1, c + 1 + T7 + W7, "R3");
    wait_to(c + 1 + T7 + W7 + 5);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected events missing, expected 0", q[0].req, q.size());
    end
    done = 1;
    finish_run();
  end
endmodule